// File: doc/BRIEF.md
# SD Card Clock Divider and Glitch-Free Gate

This block derives the SD card clock from the host bus clock. A 16-bit control register, loaded through a simple write port and always visible on a readback port, carries three things. The low byte is a one-hot field that picks a power-of-two divide ratio. One bit bypasses the divider entirely. Another bit lets the card clock run at all.

The slowest card clock is the host clock over 512. The fastest is the host clock itself. If no ratio bit is set, the ratio is 2.

Every change of ratio, mode or enable waits for a safe point. In divided mode that is the end of a complete low phase. In bypass mode it is a low phase of the host clock. Because of this, the card never sees a shortened high pulse.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the control readback is 0 and the card clock stays low.
- R2: A write updates the whole 16-bit register; the readback shows the last written value one clock later.
- R3: With bypass (bit 15) clear and bit k of bits 0..7 the lowest set select bit, the card clock period is 4·2^k host cycles, with high and low phases of 2·2^k cycles each.
- R4: With bypass clear and bits 0..7 all zero, the card clock period is 2 host cycles (one cycle high, one low).
- R5: When several of bits 0..7 are set, the lowest set bit alone decides the ratio.
- R6: With bit 15 and bit 8 set, the card clock equals the host clock (high while the host clock is high), whatever bits 0..7 hold.
- R7: With bit 8 clear, including an all-zero write, the card clock stops and stays low.
- R8: A new setting takes effect only after the running low phase has finished. A high pulse in progress always completes at full length, including when the clock is disabled in mid-pulse.
- R9: Enabling a stopped divided clock yields a first high pulse of full length.
- R10: In bypass mode, the gate opens and closes only while the host clock is low, so the last and first pulses are whole host-clock high phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load wr_data into the control register |
| wr_data | input | 16 | Control word: [7:0] one-hot ratio, [8] enable, [15] bypass |
| ctrl_rd | output | 16 | Current control register contents |
| card_clk | output | 1 | Gated card clock |

## Verification
The divider is driven with each of the eight single select bits, with an empty select field, and with bypass. For each setting, the lengths of the high and low phases are measured in half host cycles, so an off-by-one in the terminal count or a wrong bit-to-ratio mapping shows up as a wrong run length. Words with several select bits set tell a lowest-wins decode apart from a highest-wins one. A word combining bypass with select bits shows that bypass has priority. Mid-pulse disables, re-enables from a stopped state, and transitions into and out of bypass check that every observed high phase has its full length, which exposes any gating that does not wait for a low phase.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int SDCLK_CTRL_W  = 16;
    localparam int SDCLK_SEL_W   = 8;
    localparam int SDCLK_EN_BIT  = 8;
    localparam int SDCLK_BYP_BIT = 15;
endpackage

// File: rtl/sdclk_ratio_dec.sv
// Turns the one-hot select field into a half-period length in host cycles.
// The lowest set bit has priority; an empty field means a half period of 1.
module sdclk_ratio_dec #(
    parameter int SEL_W = sdclk_pkg::SDCLK_SEL_W,
    localparam int CNT_W = SEL_W + 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] half
);
    always_comb begin
        half = CNT_W'(1);
        for (int k = SEL_W - 1; k >= 0; k--) begin
            if (sel[k]) half = CNT_W'(2) << k;
        end
    end
endmodule

// File: rtl/sdclk_div_core.sv
// Rising-edge divider. Configuration is captured only at a boundary,
// which is the end of a complete low phase.
module sdclk_div_core #(
    parameter int SEL_W = sdclk_pkg::SDCLK_SEL_W,
    localparam int CNT_W = SEL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_half,
    input  logic             cfg_en,
    input  logic             cfg_byp,
    output logic             div_clk,
    output logic             act_en,
    output logic             act_byp,
    output logic             term
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
        logic             en;
        logic             byp;
        logic             clk;
    } core_t;

    core_t st_d, st_q;

    assign term = (st_q.cnt == st_q.half - CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (term && !st_q.clk) begin
            // boundary: adopt the new setting, start the next high phase if allowed
            st_d.half = cfg_byp ? CNT_W'(1) : cfg_half;
            st_d.en   = cfg_en;
            st_d.byp  = cfg_byp;
            st_d.cnt  = '0;
            // leaving bypass starts with a full low phase
            st_d.clk  = cfg_en && !cfg_byp && !st_q.byp;
        end else if (term) begin
            st_d.cnt = '0;
            st_d.clk = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.half <= CNT_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk = st_q.clk;
    assign act_en  = st_q.en;
    assign act_byp = st_q.byp;
endmodule

// File: rtl/sdclk_out_gate.sv
// Falling-edge stage: mode select and bypass gate change only while the
// host clock is low and the divided clock is low.
module sdclk_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic div_clk,
    input  logic act_en,
    input  logic act_byp,
    output logic card_clk
);
    typedef struct packed {
        logic sel;
        logic gate;
    } gate_t;

    gate_t gt_d, gt_q;

    always_comb begin
        gt_d = gt_q;
        if (!div_clk) begin
            gt_d.sel  = act_byp;
            gt_d.gate = act_byp && act_en;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gt_q <= '0;
        else        gt_q <= gt_d;
    end

    assign card_clk = gt_q.sel ? (clk & gt_q.gate) : div_clk;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int CTRL_W  = sdclk_pkg::SDCLK_CTRL_W,
    parameter int SEL_W   = sdclk_pkg::SDCLK_SEL_W,
    parameter int EN_BIT  = sdclk_pkg::SDCLK_EN_BIT,
    parameter int BYP_BIT = sdclk_pkg::SDCLK_BYP_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              card_clk
);
    localparam int CNT_W = SEL_W + 1;

    logic [CTRL_W-1:0] ctrl_d, ctrl_q;
    logic [CNT_W-1:0]  sel_half;
    logic              div_clk, act_en, act_byp, div_term;

    always_comb begin
        ctrl_d = wr_en ? wr_data : ctrl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_rd = ctrl_q;

    sdclk_ratio_dec #(.SEL_W(SEL_W)) u_dec (
        .sel  (ctrl_q[SEL_W-1:0]),
        .half (sel_half)
    );

    sdclk_div_core #(.SEL_W(SEL_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_half (sel_half),
        .cfg_en   (ctrl_q[EN_BIT]),
        .cfg_byp  (ctrl_q[BYP_BIT]),
        .div_clk  (div_clk),
        .act_en   (act_en),
        .act_byp  (act_byp),
        .term     (div_term)
    );

    sdclk_out_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_clk  (div_clk),
        .act_en   (act_en),
        .act_byp  (act_byp),
        .card_clk (card_clk)
    );
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
    parameter int CTRL_W = 16,
    parameter int SEL_W  = 8,
    parameter int EN_BIT = 8,
    localparam int CNT_W = SEL_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [CTRL_W-1:0] ctrl_rd,
    input logic              div_clk,
    input logic              term,
    input logic [CNT_W-1:0]  half_sel
);
    AST_WR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl_rd == $past(wr_data)); // R2

    AST_HALF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(half_sel) == 1); // R3

    AST_EMPTY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[SEL_W-1:0] == '0) |-> half_sel == CNT_W'(1)); // R4

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[0] |-> half_sel == CNT_W'(2)); // R5

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rd[EN_BIT] && !div_clk) |=> !div_clk); // R7

    AST_EDGE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (div_clk != $past(div_clk)) |-> $past(term)); // R8
endmodule

bind sdclk_gen sdclk_gen_chk #(.CTRL_W(CTRL_W), .SEL_W(SEL_W), .EN_BIT(EN_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ctrl_rd  (ctrl_rd),
    .div_clk  (div_clk),
    .term     (div_term),
    .half_sel (sel_half)
);

// File: tb/test_sdclk_gen.sv
`timescale 1ns/100ps
module test_sdclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ctrl_rd;
    logic        card_clk;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    sdclk_gen i_sdclk_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .card_clk(card_clk)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // phase-run monitor, one sample per half host cycle
    int   rises = 0, falls = 0, cur_hi = 0, cur_lo = 0, last_hi = 0, last_lo = 0;
    logic prev = 1'b0;
    always @(posedge clk or negedge clk) begin
        #1;
        if (rst_n) begin
            if (card_clk) begin
                if (!prev) begin rises++; last_lo = cur_lo; cur_lo = 0; end
                cur_hi++;
            end else begin
                if (prev) begin falls++; last_hi = cur_hi; cur_hi = 0; end
                cur_lo++;
            end
            prev = card_clk;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic meas(output int hi, output int lo);
        int r0 = rises;
        for (int i = 0; i < 4000 && rises < r0 + 3; i++) @(posedge clk);
        #1.5;
        hi = (rises >= r0 + 3) ? last_hi : -1;
        lo = (rises >= r0 + 3) ? last_lo : -1;
    endtask

    localparam int NV = 13;
    localparam logic [15:0] V_CTRL [NV] = '{16'h0101, 16'h0102, 16'h0104, 16'h0108,
        16'h0110, 16'h0120, 16'h0140, 16'h0180, 16'h0100, 16'h8100, 16'h81FF,
        16'h0124, 16'h01C0};
    localparam int V_RUN [NV] = '{4, 8, 16, 32, 64, 128, 256, 512, 2, 1, 1, 16, 256};
    string v_tag [NV] = '{"R3", "R3", "R3", "R3", "R3", "R3", "R3", "R3",
        "R4", "R6", "R6", "R5", "R5"};

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int hi, lo, r0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (20) @(posedge clk);
        #1;
        check(ctrl_rd == 16'h0, "R1 readback", ctrl_rd, 0);
        check(rises == 0 && card_clk == 1'b0, "R1 clock low", rises, 0);

        for (int v = 0; v < NV; v++) begin
            wr(V_CTRL[v]);
            #0.5;
            check(ctrl_rd == V_CTRL[v], "R2", ctrl_rd, V_CTRL[v]);
            meas(hi, lo);
            check(hi == V_RUN[v], {v_tag[v], " high"}, hi, V_RUN[v]);
            check(lo == V_RUN[v], {v_tag[v], " low"}, lo, V_RUN[v]);
        end

        // R8: disable in the middle of a /8 high phase
        wr(16'h0102);
        meas(hi, lo);
        for (int i = 0; i < 200 && cur_hi < 3; i++) begin @(negedge clk); #1.5; end
        r0 = falls;
        wr(16'h0000);
        for (int i = 0; i < 100 && falls == r0; i++) @(posedge clk);
        #1.5;
        check(last_hi == 8, "R8 pulse completes", last_hi, 8);
        repeat (20) @(posedge clk);
        r0 = rises;
        repeat (100) @(posedge clk);
        #1.5;
        check(rises == r0 && card_clk == 1'b0, "R7 all-zero stop", rises - r0, 0);

        // R9: re-enable from stopped state
        r0 = falls;
        wr(16'h0102);
        for (int i = 0; i < 200 && falls == r0; i++) @(posedge clk);
        #1.5;
        check(last_hi == 8, "R9 first pulse", last_hi, 8);

        // R7: enable clear, select kept
        wr(16'h0002);
        repeat (30) @(posedge clk);
        r0 = rises;
        repeat (100) @(posedge clk);
        #1.5;
        check(rises == r0, "R7 enable clear", rises - r0, 0);

        // R10: bypass gate off and back on
        wr(16'h8100);
        meas(hi, lo);
        check(hi == 1 && lo == 1, "R10 bypass run", hi, 1);
        wr(16'h8000);
        repeat (5) @(posedge clk);
        #1.5;
        check(last_hi == 1, "R10 last pulse whole", last_hi, 1);
        r0 = rises;
        repeat (50) @(posedge clk);
        #1.5;
        check(rises == r0, "R10 gate closed", rises - r0, 0);
        wr(16'h8100);
        meas(hi, lo);
        check(hi == 1, "R10 gate reopened", hi, 1);

        // R8: leaving bypass gives whole divided phases
        wr(16'h0101);
        meas(hi, lo);
        check(hi == 4 && lo == 4, "R8 bypass exit", hi, 4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule